// File: doc/BRIEF.md
# Seat Belt Reminder Controller

This block drives the warning for an unfastened driver seat belt. It watches three inputs: an ignition key level, a belt-fastened level, and a single-cycle pulse that marks each elapsed second. Its outputs are an alarm enable and a two-bit state code that is provided for debug. The block contains its own seconds counter, so it needs no outside timer. The audio generator, input debouncing and the one-second prescaler all sit outside it.

Turning the key on starts a grace interval. If the belt is still open when the grace interval expires, the alarm sounds. The alarm stops in any of three ways: when its own duration has run out, when the belt is fastened, or when the key is turned off. Once the alarm has ended because of the belt or the timeout, the controller stays silent until the key goes off and comes back on. Every key-on restarts the grace timer from zero.

Top module: `belt_reminder_ctrl`

## Requirements
- R1: After reset the state code is 0 (idle) and `alarm_o` is low.
- R2: In idle, a high key level moves the controller to waiting (state code 1) at the next clock edge. In idle, ticks and the belt level have no effect.
- R3: The seconds counter is cleared on each entry into waiting. It advances only on cycles where `sec_tick_i` is high, so a key-off and key-on in the middle of the grace interval restarts the full grace time.
- R4: In any state other than idle, a low key level returns the controller to idle (code 0) at the next edge, and `alarm_o` is low from that edge on.
- R5: In waiting with the belt open, the GRACE_SEC-th tick since key-on moves the controller to alarm (code 2). Before that tick it stays in waiting.
- R6: In alarm, a fastened belt moves the controller to silenced (code 3) at the next edge. With the belt open, the (GRACE_SEC+ALARM_SEC)-th tick since key-on also moves it to silenced.
- R7: In waiting, a fastened belt moves the controller to silenced (code 3). Silenced is left only by a low key level. Ticks and releasing the belt keep it in silenced.
- R8: `alarm_o` is a register output that is high exactly in the cycles where the state code is 2. There is no same-cycle path from any input to `alarm_o`.
- R9: When several conditions coincide in the same cycle, a low key level wins over a fastened belt, and a fastened belt wins over a timer expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_on_i | input | 1 | Ignition key level, 1 = on |
| belt_on_i | input | 1 | Belt level, 1 = fastened |
| sec_tick_i | input | 1 | One-cycle pulse per elapsed second |
| alarm_o | output | 1 | Alarm enable, registered |
| state_o | output | 2 | State code: 0 idle, 1 waiting, 2 alarm, 3 silenced |

## Verification
The state code is a register output, so a wrong transition shows on `state_o` one edge after the input that caused it. A fault in the seconds counter stays hidden until the fifth or tenth tick after key-on. At that point the alarm either starts or stops one tick early or late, which makes the tick counts just before and just after each limit the cycles that matter. A stale counter shows up only after a key cycle in the middle of the interval, where the alarm would start too soon. A controller that fails to hold silenced would drop back into the alarm path on later ticks.

// File: rtl/belt_reminder_pkg.sv
package belt_reminder_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAITING = 2'd1,
        ST_ALARM   = 2'd2,
        ST_SILENT  = 2'd3
    } brm_state_e;

    typedef struct packed {
        brm_state_e state;
        logic       alarm;
    } brm_ctl_regs_t;

endpackage

// File: rtl/brm_sec_timer.sv
module brm_sec_timer #(
    parameter int unsigned LIMIT = 10,
    parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.cnt = '0;
        end else if (tick_i && (r_q.cnt != SAT_VAL)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_o = r_q.cnt;

    // R3: a clear request zeroes the count at the next edge
    a_r3_clear_zero : assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

    // R3: without a tick the count holds its value
    a_r3_hold_no_tick : assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !tick_i) |=> $stable(cnt_o));

endmodule

// File: rtl/brm_ctl_fsm.sv
module brm_ctl_fsm
    import belt_reminder_pkg::*;
#(
    parameter int unsigned GRACE_SEC = 5,
    parameter int unsigned ALARM_SEC = 5,
    parameter int unsigned CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_i,
    input  logic             belt_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             clr_o,
    output brm_state_e       state_o,
    output logic             alarm_o
);

    localparam logic [CNT_W-1:0] GRACE_LAST = CNT_W'(GRACE_SEC - 1);
    localparam logic [CNT_W-1:0] TOTAL_LAST = CNT_W'(GRACE_SEC + ALARM_SEC - 1);

    brm_ctl_regs_t r_d, r_q;
    logic grace_end, alarm_end;

    always_comb begin
        grace_end = tick_i && (cnt_i == GRACE_LAST);
        alarm_end = tick_i && (cnt_i == TOTAL_LAST);
        r_d       = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (key_i) r_d.state = ST_WAITING;
            end
            ST_WAITING: begin
                if (!key_i)         r_d.state = ST_IDLE;
                else if (belt_i)    r_d.state = ST_SILENT;
                else if (grace_end) r_d.state = ST_ALARM;
            end
            ST_ALARM: begin
                if (!key_i)         r_d.state = ST_IDLE;
                else if (belt_i)    r_d.state = ST_SILENT;
                else if (alarm_end) r_d.state = ST_SILENT;
            end
            ST_SILENT: begin
                if (!key_i) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.alarm = (r_d.state == ST_ALARM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, alarm: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign clr_o   = (r_q.state == ST_IDLE) && key_i;
    assign state_o = r_q.state;
    assign alarm_o = r_q.alarm;

    // R2: key-on in idle always reaches waiting
    a_r2_enter_waiting : assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE && key_i) |=> (state_o == ST_WAITING));

    // R4: key-off anywhere returns to idle with the alarm low
    a_r4_key_off_idle : assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_IDLE && !key_i) |=> (state_o == ST_IDLE && !alarm_o));

    // R5: the alarm can only start from waiting
    a_r5_alarm_from_wait : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> ($past(state_o) == ST_WAITING));

    // R7: silenced holds while the key stays on
    a_r7_silent_holds : assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SILENT && key_i) |=> (state_o == ST_SILENT));

    // R8: alarm register agrees with the state register
    a_r8_alarm_decode : assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o == (state_o == ST_ALARM));

endmodule

// File: rtl/belt_reminder_ctrl.sv
module belt_reminder_ctrl
    import belt_reminder_pkg::*;
#(
    parameter int unsigned GRACE_SEC = 5,
    parameter int unsigned ALARM_SEC = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_on_i,
    input  logic       belt_on_i,
    input  logic       sec_tick_i,
    output logic       alarm_o,
    output logic [1:0] state_o
);

    localparam int unsigned TOTAL_SEC = GRACE_SEC + ALARM_SEC;
    localparam int unsigned CNT_W     = $clog2(TOTAL_SEC + 1);

    logic             tmr_clr;
    logic [CNT_W-1:0] tmr_cnt;
    brm_state_e       fsm_state;

    brm_sec_timer #(
        .LIMIT (TOTAL_SEC),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .tick_i (sec_tick_i),
        .cnt_o  (tmr_cnt)
    );

    brm_ctl_fsm #(
        .GRACE_SEC (GRACE_SEC),
        .ALARM_SEC (ALARM_SEC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_i   (key_on_i),
        .belt_i  (belt_on_i),
        .tick_i  (sec_tick_i),
        .cnt_i   (tmr_cnt),
        .clr_o   (tmr_clr),
        .state_o (fsm_state),
        .alarm_o (alarm_o)
    );

    assign state_o = fsm_state;

endmodule

// File: tb/belt_reminder_ctrl_tb_top.sv
module belt_reminder_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key = 1'b0;
    logic       belt = 1'b0;
    logic       tick = 1'b0;
    logic       alarm;
    logic [1:0] st;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    belt_reminder_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_on_i   (key),
        .belt_on_i  (belt),
        .sec_tick_i (tick),
        .alarm_o    (alarm),
        .state_o    (st)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
            step();
        end
    endtask

    task automatic expect_out(input string req, input logic [1:0] exp_st, input logic exp_al);
        n_checks++;
        if (st !== exp_st || alarm !== exp_al) begin
            n_fail++;
            $display("FAIL %s: state=%0d alarm=%0d expected state=%0d alarm=%0d",
                     req, st, alarm, exp_st, exp_al);
        end
    endtask

    task automatic go_idle();
        key = 1'b0; belt = 1'b0; tick = 1'b0;
        step();
    endtask

    task automatic t_reset();
        expect_out("R1", 2'd0, 1'b0);
    endtask

    task automatic t_idle_ignores();
        belt = 1'b1;
        ticks(3);
        expect_out("R2", 2'd0, 1'b0);
        belt = 1'b0;
        key = 1'b1;
        step();
        expect_out("R2", 2'd1, 1'b0);
        go_idle();
    endtask

    task automatic t_full_alarm();
        key = 1'b1; step();
        ticks(4);
        expect_out("R5", 2'd1, 1'b0);
        ticks(1);
        expect_out("R5", 2'd2, 1'b1);
        ticks(4);
        expect_out("R8", 2'd2, 1'b1);
        ticks(1);
        expect_out("R6", 2'd3, 1'b0);
        ticks(6);
        expect_out("R7", 2'd3, 1'b0);
        key = 1'b0; step();
        expect_out("R4", 2'd0, 1'b0);
    endtask

    task automatic t_belt_at_three();
        key = 1'b1; step();
        ticks(3);
        belt = 1'b1; step();
        expect_out("R7", 2'd3, 1'b0);
        ticks(5);
        expect_out("R7", 2'd3, 1'b0);
        belt = 1'b0;
        ticks(8);
        expect_out("R7", 2'd3, 1'b0);
        go_idle();
        expect_out("R4", 2'd0, 1'b0);
    endtask

    task automatic t_belt_in_alarm();
        key = 1'b1; step();
        ticks(5);
        expect_out("R5", 2'd2, 1'b1);
        belt = 1'b1; step();
        expect_out("R6", 2'd3, 1'b0);
        go_idle();
    endtask

    task automatic t_key_off_in_alarm();
        key = 1'b1; step();
        ticks(6);
        expect_out("R5", 2'd2, 1'b1);
        key = 1'b0; step();
        expect_out("R4", 2'd0, 1'b0);
        ticks(10);
        expect_out("R4", 2'd0, 1'b0);
    endtask

    task automatic t_restart();
        key = 1'b1; step();
        ticks(3);
        key = 1'b0; step();
        key = 1'b1; step();
        expect_out("R3", 2'd1, 1'b0);
        ticks(4);
        expect_out("R3", 2'd1, 1'b0);
        for (int i = 0; i < 5; i++) step();
        expect_out("R3", 2'd1, 1'b0);
        ticks(1);
        expect_out("R3", 2'd2, 1'b1);
        go_idle();
    endtask

    task automatic t_priority();
        key = 1'b1; step();
        ticks(4);
        key = 1'b0; belt = 1'b1; tick = 1'b1;
        step();
        tick = 1'b0; belt = 1'b0;
        expect_out("R9", 2'd0, 1'b0);
        key = 1'b1; step();
        ticks(4);
        belt = 1'b1; tick = 1'b1;
        step();
        tick = 1'b0;
        expect_out("R9", 2'd3, 1'b0);
        go_idle();
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_idle_ignores();
        t_full_alarm();
        t_belt_at_three();
        t_belt_in_alarm();
        t_key_off_in_alarm();
        t_restart();
        t_priority();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule